// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Controller

This block sequences single-byte accesses to an 8-bit asynchronous NAND-style device. A host issues one request at a time. The controller then walks the external pins through four timed phases: a setup phase with the chip select low, a strobe phase with the read or write enable low, a hold phase, and a turnaround phase with the chip select high. The lengths of these phases come from one packed 32-bit timing word. Reads and writes each have their own setup, strobe and hold counts, and both share one turnaround count.

Two latched steering lines mark command and address cycles. They change only on a control request that carries the steer flag, and they take their new values from two chosen bits of the request selector. A control request can also skip its bus cycle, which stands for the "no command byte" case. The device ready pin is synchronised and appears as bit 0 of a status word.

Top module: `amem_strobe_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are high, mem_dq_oe, mem_cle, mem_ale and rsp_valid are low, req_ready is high and stat_o is zero. While req_ready is high, no strobe and no chip select is active.
- R2: The timing word holds these fields: bits 29:26 write setup, 25:20 write strobe, 19:17 write hold, 16:13 read setup, 12:7 read strobe and 6:4 read hold. Each phase lasts its field value plus one clock cycle. A read uses the read fields and a write uses the write fields.
- R3: An accepted access runs setup (chip select low, both strobes high), then strobe (mem_oe_n low for a read or mem_we_n low for a write, never both), then hold (strobes high, chip select low). It then runs turnaround for bits 3:2 plus one cycles, with chip select high and req_ready low. After that, req_ready returns high.
- R4: During a write, mem_dq_oe is high and mem_dq_o carries the request byte from the first setup cycle through the last hold cycle. mem_dq_oe is low at all other times and during every read.
- R5: A read captures mem_dq_i on the last strobe cycle. rsp_valid is high for exactly the first hold cycle, and rsp_rdata then holds the captured byte. A write produces no rsp_valid.
- R6: When bit 31 of the timing word is 1, mem_cs_n is low only during the strobe phase.
- R7: A control request with req_steer set loads mem_cle from req_sel[CLE_BIT] and mem_ale from req_sel[ALE_BIT], replacing both old values. Every other request leaves both lines unchanged.
- R8: A control request with req_skip set starts no bus cycle. mem_cs_n stays high and req_ready is high again on the next cycle. A control request without req_skip runs a write access of req_wdata.
- R9: The timing word is captured when a request is accepted. Changing cfg_word during an access does not change that access's phase lengths.
- R10: stat_o bit 0 shows mem_rdy after SYNC_STAGES rising edges. Bit 1 shows bit 30 of the live timing word. All other bits of stat_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted this cycle |
| req_ctl | input | 1 | Control request (steering and/or command byte) |
| req_wr | input | 1 | Data request direction, 1 = write |
| req_steer | input | 1 | Reload steering lines from req_sel |
| req_skip | input | 1 | Control request without a bus cycle |
| req_sel | input | ADDR_W | Selector bits carrying steering values |
| req_wdata | input | DATA_W | Write or command byte |
| rsp_valid | output | 1 | Read byte available |
| rsp_rdata | output | DATA_W | Captured read byte |
| stat_o | output | STAT_W | Status: bit 0 ready, bit 1 extended-wait flag |
| mem_rdy | input | 1 | Device ready pin (asynchronous) |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cle | output | 1 | Command latch steering line |
| mem_ale | output | 1 | Address latch steering line |
| mem_dq_o | output | DATA_W | Data driven to the device |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | DATA_W | Data from the device |

## Verification
The bench builds the block with its defaults: 8-bit data, an 8-bit selector with steering on bits 1 and 2, and a two-stage ready synchroniser. With these values, random timing words cover every field value, including strobes of 64 cycles, zero-length fields and select-strobe mode. They also make the two-edge latency of the ready bit directly observable. Because the steering bits sit low in the selector, random selectors toggle each line independently.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef struct packed {
    logic       sel_strobe;
    logic       ext_wait;
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] turn;
  } timing_t;

  // Field extraction; bits 1:0 (bus size) carry no behaviour for an 8-bit port.
  function automatic timing_t unpack_timing(input logic [CFG_W-1:0] w);
    timing_t t;
    t.sel_strobe = w[31];
    t.ext_wait   = w[30];
    t.wr_setup   = w[29:26];
    t.wr_strobe  = w[25:20];
    t.wr_hold    = w[19:17];
    t.rd_setup   = w[16:13];
    t.rd_strobe  = w[12:7];
    t.rd_hold    = w[6:4];
    t.turn       = w[3:2];
    return t;
  endfunction

  // Counter preload for a phase: the phase lasts preload + 1 cycles.
  function automatic logic [CNT_W-1:0] phase_load(input timing_t t, input logic wr,
                                                   input phase_e ph);
    logic [CNT_W-1:0] v;
    case (ph)
      PH_SETUP:  v = wr ? CNT_W'(t.wr_setup)  : CNT_W'(t.rd_setup);
      PH_STROBE: v = wr ? CNT_W'(t.wr_strobe) : CNT_W'(t.rd_strobe);
      PH_HOLD:   v = wr ? CNT_W'(t.wr_hold)   : CNT_W'(t.rd_hold);
      PH_TURN:   v = CNT_W'(t.turn);
      default:   v = '0;
    endcase
    return v;
  endfunction

  function automatic phase_e next_phase(input phase_e ph);
    phase_e n;
    case (ph)
      PH_SETUP:  n = PH_STROBE;
      PH_STROBE: n = PH_HOLD;
      PH_HOLD:   n = PH_TURN;
      default:   n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/amem_rdy_sync.sv
module amem_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= d_i;
      end
      assign q_o = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[STAGES-2:0], d_i};
      end
      assign q_o = s_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/amem_phase_fsm.sv
module amem_phase_fsm
  import amem_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    wr_i,
  input  timing_t tcfg_i,
  output phase_e  phase_o,
  output logic    last_o,
  output logic    wr_o,
  output timing_t tcfg_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  timing_t          tcfg_q;
  phase_e           ph_nxt;

  assign last_o = (cnt_q == '0);
  assign ph_nxt = next_phase(ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      tcfg_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q   <= PH_SETUP;
        cnt_q  <= phase_load(tcfg_i, wr_i, PH_SETUP);
        wr_q   <= wr_i;
        tcfg_q <= tcfg_i;
      end
    end else if (last_o) begin
      ph_q  <= ph_nxt;
      cnt_q <= phase_load(tcfg_q, wr_q, ph_nxt);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign wr_o    = wr_q;
  assign tcfg_o  = tcfg_q;

  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !last_o) |=> (ph_q == $past(ph_q))); // R2

  AST_TURN_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TURN && last_o) |=> (ph_q == PH_IDLE)); // R3

endmodule

// File: rtl/amem_strobe_ctrl.sv
module amem_strobe_ctrl
  import amem_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int CLE_BIT     = 1,
  parameter int ALE_BIT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ctl,
  input  logic              req_wr,
  input  logic              req_steer,
  input  logic              req_skip,
  input  logic [ADDR_W-1:0] req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [STAT_W-1:0] stat_o,
  input  logic              mem_rdy,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_cle,
  output logic              mem_ale,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int PAD_W = STAT_W - 2;

  timing_t           tcfg_live;
  timing_t           tcfg_lat;
  phase_e            phase;
  logic              ph_last;
  logic              acc_wr;
  logic              accept;
  logic              bus_start;
  logic              bus_wr;
  logic              steer_load;
  logic              in_access;
  logic              in_strobe;
  logic              read_capture;
  logic              cle_q, ale_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;
  logic              rdy_sync;
  logic              unused_bits;

  assign tcfg_live    = unpack_timing(cfg_word);
  assign accept       = req_valid && req_ready;
  assign bus_start    = accept && !(req_ctl && req_skip);
  assign bus_wr       = req_ctl ? 1'b1 : req_wr;
  assign steer_load   = accept && req_ctl && req_steer;
  assign in_access    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe    = (phase == PH_STROBE);
  assign read_capture = in_strobe && ph_last && !acc_wr;

  amem_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (bus_start),
    .wr_i    (bus_wr),
    .tcfg_i  (tcfg_live),
    .phase_o (phase),
    .last_o  (ph_last),
    .wr_o    (acc_wr),
    .tcfg_o  (tcfg_lat)
  );

  amem_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mem_rdy),
    .q_o   (rdy_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (steer_load) begin
        cle_q <= req_sel[CLE_BIT];
        ale_q <= req_sel[ALE_BIT];
      end
      if (bus_start) wdata_q <= req_wdata;
      if (read_capture) rdata_q <= mem_dq_i;
      rsp_q <= read_capture;
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign mem_cs_n  = tcfg_lat.sel_strobe ? !in_strobe : !in_access;
  assign mem_oe_n  = !(in_strobe && !acc_wr);
  assign mem_we_n  = !(in_strobe && acc_wr);
  assign mem_dq_oe = in_access && acc_wr;
  assign mem_dq_o  = wdata_q;
  assign mem_cle   = cle_q;
  assign mem_ale   = ale_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign stat_o    = {{PAD_W{1'b0}}, tcfg_live.ext_wait, rdy_sync};

  assign unused_bits = ^{cfg_word[1:0], req_sel, tcfg_lat.ext_wait, tcfg_lat.wr_setup,
                         tcfg_lat.wr_strobe, tcfg_lat.wr_hold, tcfg_lat.rd_setup,
                         tcfg_lat.rd_strobe, tcfg_lat.rd_hold, tcfg_lat.turn};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R3

  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R3

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R4

  AST_RSP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (phase == PH_HOLD && !acc_wr)); // R5

  AST_STEER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !steer_load |=> $stable({mem_cle, mem_ale})); // R7

endmodule

// File: tb/amem_strobe_ctrl_tb.sv
module amem_strobe_ctrl_tb;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int CLE_B = 1;
  localparam int ALE_B = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic          req_valid = 0, req_ctl = 0, req_wr = 0, req_steer = 0, req_skip = 0;
  logic [AW-1:0] req_sel = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [7:0]    stat_o;
  logic          mem_rdy = 1'b0;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_cle, mem_ale, mem_dq_oe;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i = '0;

  int n_run = 0;
  int n_fail = 0;
  bit exp_cle = 0, exp_ale = 0;

  always #5 clk = ~clk;

  amem_strobe_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CLE_BIT(CLE_B), .ALE_BIT(ALE_B),
                     .SYNC_STAGES(2), .STAT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_ready(req_ready), .req_ctl(req_ctl), .req_wr(req_wr), .req_steer(req_steer),
    .req_skip(req_skip), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stat_o(stat_o), .mem_rdy(mem_rdy),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_cle(mem_cle),
    .mem_ale(mem_ale), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fld(input logic [31:0] w, input int lo, input int n);
    return int'((w >> lo) & ((32'd1 << n) - 32'd1));
  endfunction

  // Expected phase lengths restated from the requirements.
  function automatic int len_setup(input logic [31:0] w, input bit wr);
    return (wr ? fld(w, 26, 4) : fld(w, 13, 4)) + 1;
  endfunction
  function automatic int len_strobe(input logic [31:0] w, input bit wr);
    return (wr ? fld(w, 20, 6) : fld(w, 7, 6)) + 1;
  endfunction
  function automatic int len_hold(input logic [31:0] w, input bit wr);
    return (wr ? fld(w, 17, 3) : fld(w, 4, 3)) + 1;
  endfunction
  function automatic int len_turn(input logic [31:0] w);
    return fld(w, 2, 2) + 1;
  endfunction

  task automatic run_access(input logic [31:0] w, input logic [31:0] w_after, input bit ctl,
                            input bit wr, input bit steer, input logic [AW-1:0] sel,
                            input logic [DW-1:0] wd);
    int n_su = 0, n_st = 0, n_ho = 0, n_ta = 0, n_busy = 0, n_rsp = 0;
    int bad_dq = 0, bad_ss = 0, bad_data = 0, bad_steer = 0, bad_rsp = 0;
    bit seen_st = 0, prev_st = 0;
    bit iswr = ctl | wr;
    bit ss = w[31];
    logic [DW-1:0] last_dq = '0;
    string tg = (w_after != w) ? "R9" : "R2";
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_word = w; req_valid = 1; req_ctl = ctl; req_wr = wr; req_steer = steer;
    req_skip = 0; req_sel = sel; req_wdata = wd;
    if (ctl && steer) begin exp_cle = sel[CLE_B]; exp_ale = sel[ALE_B]; end
    @(negedge clk);
    req_valid = 0; cfg_word = w_after; req_wdata = ~wd;
    while (!req_ready && n_busy < 200) begin
      bit stb = iswr ? !mem_we_n : !mem_oe_n;
      bit act = ss ? (iswr && mem_dq_oe) : !mem_cs_n;
      n_busy++;
      if (stb) begin
        n_st++; seen_st = 1;
        if (iswr && mem_dq_o !== wd) bad_data++;
      end else if (act && !seen_st) n_su++;
      else if (act && seen_st) n_ho++;
      else n_ta++;
      if (!iswr && mem_dq_oe) bad_dq++;
      if (iswr && !ss && (mem_dq_oe != !mem_cs_n)) bad_dq++;
      if (ss && (mem_cs_n != !stb)) bad_ss++;
      if (mem_cle != exp_cle || mem_ale != exp_ale) bad_steer++;
      if (rsp_valid) begin
        n_rsp++;
        if (!(prev_st && !stb) || rsp_rdata !== last_dq) bad_rsp++;
      end
      prev_st = stb;
      mem_dq_i = DW'($urandom);
      if (stb) last_dq = mem_dq_i;
      @(negedge clk);
    end
    check(n_busy == len_setup(w, iswr) + len_strobe(w, iswr) + len_hold(w, iswr) + len_turn(w),
          {tg, "/R3 busy length"}, n_busy,
          len_setup(w, iswr) + len_strobe(w, iswr) + len_hold(w, iswr) + len_turn(w));
    check(n_st == len_strobe(w, iswr), {tg, " strobe length"}, n_st, len_strobe(w, iswr));
    if (!ss || iswr) begin
      check(n_su == len_setup(w, iswr), {tg, " setup length"}, n_su, len_setup(w, iswr));
      check(n_ho == len_hold(w, iswr), {tg, " hold length"}, n_ho, len_hold(w, iswr));
      check(n_ta == len_turn(w), "R3 turnaround length", n_ta, len_turn(w));
    end
    check(bad_dq == 0, "R4 data enable window", bad_dq, 0);
    check(bad_data == 0, "R4 write data value", bad_data, 0);
    check(bad_ss == 0, "R6 select-strobe chip select", bad_ss, 0);
    check(bad_steer == 0, "R7 steering lines", bad_steer, 0);
    check(n_rsp == (iswr ? 0 : 1), "R5 response count", n_rsp, iswr ? 0 : 1);
    check(bad_rsp == 0, "R5 response timing/data", bad_rsp, 0);
    if (ctl) check(iswr, "R8 control request writes", int'(iswr), 1);
  endtask

  task automatic run_skip(input bit steer, input logic [AW-1:0] sel);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_ctl = 1; req_skip = 1; req_steer = steer; req_sel = sel;
    req_wdata = 8'h5A;
    if (steer) begin exp_cle = sel[CLE_B]; exp_ale = sel[ALE_B]; end
    @(negedge clk);
    req_valid = 0; req_skip = 0; req_steer = 0;
    check(req_ready == 1'b1, "R8 skip stays idle", int'(req_ready), 1);
    check(mem_cle == exp_cle, "R7 cle after control", int'(mem_cle), int'(exp_cle));
    check(mem_ale == exp_ale, "R7 ale after control", int'(mem_ale), int'(exp_ale));
    for (int k = 0; k < 3; k++) begin
      check(mem_cs_n == 1'b1 && mem_we_n == 1'b1, "R8 no bus cycle on skip",
            int'(mem_cs_n), 1);
      @(negedge clk);
    end
  endtask

  localparam logic [31:0] TYPICAL = (32'd1 << 26) | (32'd3 << 20) | (32'd1 << 17) |
                                    (32'd1 << 13) | (32'd5 << 7) | (32'd1 << 4) | (32'd3 << 2);

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held and right after release
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", int'(mem_cs_n), 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(!mem_dq_oe && !mem_cle && !mem_ale && !rsp_valid, "R1 quiet outputs",
          int'({mem_dq_oe, mem_cle, mem_ale, rsp_valid}), 0);
    check(stat_o == 8'h00, "R1 status zero", int'(stat_o), 0);

    // R2/R3 typical timing, both directions
    run_access(TYPICAL, TYPICAL, 0, 1, 0, '0, 8'hA5);
    run_access(TYPICAL, TYPICAL, 0, 0, 0, '0, 8'h00);
    // all fields zero and all fields maximal
    run_access(32'h0, 32'h0, 0, 0, 0, '0, 8'h00);
    run_access(32'h0, 32'h0, 0, 1, 0, '0, 8'h3C);
    run_access(32'h3FFF_FFFC, 32'h3FFF_FFFC, 0, 0, 0, '0, 8'h00);
    run_access(32'h3FFF_FFFC, 32'h3FFF_FFFC, 0, 1, 0, '0, 8'hFF);
    // R6 select-strobe mode
    run_access(TYPICAL | 32'h8000_0000, TYPICAL | 32'h8000_0000, 0, 1, 0, '0, 8'h81);
    run_access(TYPICAL | 32'h8000_0000, TYPICAL | 32'h8000_0000, 0, 0, 0, '0, 8'h00);
    // R9 timing word changed mid-access
    run_access(TYPICAL, 32'h3FFF_FFFC, 0, 0, 0, '0, 8'h00);
    run_access(32'h3FFF_FFFC, 32'h0, 0, 1, 0, '0, 8'h42);
    // R7/R8 steering and skipped command byte
    run_skip(1, 8'b0000_0010);
    run_skip(0, 8'b0000_0100);
    run_skip(1, 8'b0000_0100);
    run_skip(1, 8'b1111_1001);
    run_access(TYPICAL, TYPICAL, 1, 0, 1, 8'b0000_0010, 8'h70);
    run_access(TYPICAL, TYPICAL, 0, 0, 0, 8'b0000_0100, 8'h00);
    run_access(TYPICAL, TYPICAL, 1, 0, 0, 8'b0000_0110, 8'h90);

    // R10 ready synchroniser latency and flag bit
    @(negedge clk);
    mem_rdy = 1;
    @(negedge clk);
    check(stat_o[0] == 1'b0, "R10 ready after one edge", int'(stat_o[0]), 0);
    @(negedge clk);
    check(stat_o[0] == 1'b1, "R10 ready after two edges", int'(stat_o[0]), 1);
    mem_rdy = 0;
    repeat (2) @(negedge clk);
    check(stat_o[0] == 1'b0, "R10 ready falls", int'(stat_o[0]), 0);
    cfg_word = 32'h4000_0000;
    #1;
    check(stat_o == 8'h02, "R10 extended-wait flag", int'(stat_o), 2);
    cfg_word = 32'hBFFF_FFFF;
    #1;
    check(stat_o == 8'h00, "R10 other status bits zero", int'(stat_o), 0);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w = $urandom;
      logic [31:0] wa = (i % 5 == 0) ? $urandom : w;
      bit ctl = ($urandom % 4) == 0;
      bit wr = $urandom % 2;
      logic [AW-1:0] sel = AW'($urandom);
      if (ctl && ($urandom % 3) == 0) run_skip($urandom % 2, sel);
      else run_access(w, wa, ctl, wr, $urandom % 2, sel, DW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule